// File: doc/BRIEF.md
# Interlaced Raster Sync Timing Generator

This block produces the horizontal and vertical sync timing for an interlaced standard-definition raster. Both 525-line and 625-line styles can be expressed. The raster is counted in device clocks across the line and in half-lines down the field. An odd number of half-lines per field makes successive fields start alternately at a line start and at mid-line, which is what gives interlace. Around each vertical sync the block emits equalization pulses and serrated broad pulses on the sync output. On normal lines it emits a single hsync pulse at the line start.

A write port loads the timing parameters into a staging copy. The staging copy is moved into the live copy only when a frame ends, so a raster is never built from a mix of old and new values. One mode field sets the sync direction. As master, the block drives its sync outputs and asserts the output enable. As slave, it watches external sync inputs instead: it re-aligns its pixel counter to incoming hsync edges near a line start, and its half-line counter and field identity to incoming vsync edges.

Besides the sync outputs, the block provides an active-video enable, the field identity, a bottom-field flag, the line and half-line counters, and a one-clock pulse at each field start.

Top module: `raster_sync_gen`

## Requirements
- R1: In master mode `hcount` counts 0 up to 2×HALF−1 and wraps to 0, so a line lasts twice the half-line length HALF (register 0); after reset it reads 0.
- R2: `vcount` counts half-lines 0 up to FLD−1 (register 7, half-lines per field), advancing when `hcount` leaves HALF−1 or 2×HALF−1; `field_id` (0 = top, 1 = bottom) toggles each time `vcount` wraps to 0.
- R3: Outside the vertical interval, `hs_out` is high while `hcount` is below the hsync width (register 1).
- R4: In half-lines [0, EQN) and [2×EQN, 3×EQN), where EQN is register 6, `hs_out` is high for the first EQW clocks of every half-line (EQW is register 2).
- R5: In half-lines [EQN, 2×EQN), `vs_out` is high, and `hs_out` is high from each half-line start until SERW clocks before that half-line ends (SERW is register 3).
- R6: `active_de` is high when `hcount` lies in [ASTART, ASTART+AWIDTH) and `vcount` lies in [VSTART, VSTART+VCOUNT) (registers 4, 5, 8 and 9). AWIDTH counts clocks, so it is twice the pixel count.
- R7: `bottom_flag` takes the value of `field_id` one clock after the first line start (`hcount` = 0) that follows the rise of the vertical sync interval. A line start in the same cycle as that rise does not count.
- R8: Writes go to addresses 0 to 10 (register 10 bit 0 = master). They have no effect until the clock after the last cycle of a bottom field, when all of them take effect together.
- R9: `vsync_irq` is high for exactly one clock at each field start (`vcount` = 0 and the first clock of a half-line), except the state directly after reset.
- R10: `sync_oe` equals the master bit. In slave mode, an `hs_in` rising edge seen with `hcount` below HALF/2 or at least 3×HALF/2 forces `hcount` to 0 two clocks after the edge. If `hcount` was at HALF or above, `vcount` advances once. Edges nearer mid-line are ignored.
- R11: In slave mode, a `vs_in` rising edge sets `vcount` to EQN two clocks after the edge. `field_id` becomes 1 if `hcount` lay in [HALF/2, 3×HALF/2) at the edge and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Parameter write strobe |
| wr_addr | input | 4 | Parameter index |
| wr_data | input | 12 | Parameter value |
| hs_in | input | 1 | External horizontal sync (slave mode) |
| vs_in | input | 1 | External vertical sync (slave mode) |
| hs_out | output | 1 | Generated horizontal/composite sync pulse train |
| vs_out | output | 1 | Generated vertical sync interval |
| sync_oe | output | 1 | High when the block drives sync (master) |
| active_de | output | 1 | Active-video enable |
| field_id | output | 1 | Current field, 1 = bottom |
| bottom_flag | output | 1 | Bottom-field flag updated after vertical sync |
| hcount | output | 13 | Clock position within the line |
| vcount | output | 12 | Half-line position within the field |
| vsync_irq | output | 1 | One-clock pulse at field start |

## Verification
Two complete rasters are compared clock by clock against an arithmetic model. One has an odd equalization count, so vertical sync begins mid-line in the top field. The other has an even count and a different line length, so vertical sync begins exactly on a line start. The two tell apart the half-line phase of each region and the rule for the bottom flag. Writes made in the middle of a frame show whether the old timing holds to the frame end and whether the new timing starts cleanly. In slave mode, sync edges placed near a line end, at mid-line, at a line start and at a half-line show whether edges lock or are ignored, and whether the field is detected correctly.

// File: rtl/raster_pkg.sv
// Shared definitions for the raster timing generator.
// Assumes every timing parameter fits in RASTER_CW bits.
package raster_pkg;
    localparam int RASTER_CW = 12;

    // Register indices on the parameter write port
    localparam int IDX_HALF   = 0;
    localparam int IDX_HSW    = 1;
    localparam int IDX_EQW    = 2;
    localparam int IDX_SERW   = 3;
    localparam int IDX_ASTART = 4;
    localparam int IDX_AWIDTH = 5;
    localparam int IDX_EQN    = 6;
    localparam int IDX_FLD    = 7;
    localparam int IDX_VSTART = 8;
    localparam int IDX_VCOUNT = 9;
    localparam int IDX_MODE   = 10;

    typedef struct packed {
        logic [RASTER_CW-1:0] half_len;
        logic [RASTER_CW-1:0] hs_width;
        logic [RASTER_CW-1:0] eq_width;
        logic [RASTER_CW-1:0] serr_width;
        logic [RASTER_CW-1:0] act_start;
        logic [RASTER_CW-1:0] act_width;
        logic [RASTER_CW-1:0] eq_count;
        logic [RASTER_CW-1:0] field_halves;
        logic [RASTER_CW-1:0] vact_start;
        logic [RASTER_CW-1:0] vact_count;
        logic                 master;
    } raster_cfg_t;
endpackage

// File: rtl/raster_cfg_regs.sv
// Parameter store: a staging copy written from the port and a live copy
// loaded from it only on the frame-boundary strobe.
// Assumes writes and the strobe do not coincide with a needed update.
module raster_cfg_regs
    import raster_pkg::*;
#(
    parameter int          AW        = 4,
    parameter raster_cfg_t RESET_CFG = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [RASTER_CW-1:0] wr_data,
    input  logic                 apply,
    output raster_cfg_t          live
);
    raster_cfg_t staged;

    // Capture port writes into the staging copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged <= RESET_CFG;
        end else if (wr_en) begin
            case (int'(wr_addr))
                IDX_HALF:   staged.half_len     <= wr_data;
                IDX_HSW:    staged.hs_width     <= wr_data;
                IDX_EQW:    staged.eq_width     <= wr_data;
                IDX_SERW:   staged.serr_width   <= wr_data;
                IDX_ASTART: staged.act_start    <= wr_data;
                IDX_AWIDTH: staged.act_width    <= wr_data;
                IDX_EQN:    staged.eq_count     <= wr_data;
                IDX_FLD:    staged.field_halves <= wr_data;
                IDX_VSTART: staged.vact_start   <= wr_data;
                IDX_VCOUNT: staged.vact_count   <= wr_data;
                IDX_MODE:   staged.master       <= wr_data[0];
                default:    ;
            endcase
        end
    end

    // Move staging to live at the frame boundary only
    always_ff @(posedge clk) begin
        if (!rst_n)     live <= RESET_CFG;
        else if (apply) live <= staged;
    end

    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(apply) |-> (live == $past(live)));
endmodule

// File: rtl/raster_counters.sv
// Pixel, half-line and field counters. Free-running in master mode;
// in slave mode re-aligned by synchronised external sync edges.
// Assumes half_len >= 2 and an odd field_halves for interlace.
module raster_counters #(
    parameter int CW = raster_pkg::RASTER_CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] half_len,
    input  logic [CW-1:0] eq_count,
    input  logic [CW-1:0] field_halves,
    input  logic          master,
    input  logic          hs_in,
    input  logic          vs_in,
    output logic [CW:0]   hpos,
    output logic [CW-1:0] vpos,
    output logic          field,
    output logic          apply,
    output logic          irq
);
    logic          hs_q, hs_q2, vs_q, vs_q2;
    logic [CW:0]   half_w, line_len, quarter, three_q;
    logic          at_line_end, at_half_end, near_start, mid_line;
    logic          hs_lock, vs_lock, half_step, vpos_last;

    // Two-stage capture of the external sync inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q <= 1'b0; hs_q2 <= 1'b0; vs_q <= 1'b0; vs_q2 <= 1'b0;
        end else begin
            hs_q <= hs_in; hs_q2 <= hs_q; vs_q <= vs_in; vs_q2 <= vs_q;
        end
    end

    // Boundary and lock decisions for the current cycle
    always_comb begin
        half_w      = {1'b0, half_len};
        line_len    = {half_len, 1'b0};
        quarter     = {2'b00, half_len[CW-1:1]};
        three_q     = half_w + quarter;
        at_line_end = (hpos == line_len - 1'b1);
        at_half_end = (hpos == half_w - 1'b1) || at_line_end;
        near_start  = (hpos >= three_q) || (hpos < quarter);
        mid_line    = (hpos >= quarter) && (hpos < three_q);
        hs_lock     = !master && hs_q && !hs_q2 && near_start;
        vs_lock     = !master && vs_q && !vs_q2;
        half_step   = hs_lock ? (hpos >= half_w) : at_half_end;
        vpos_last   = (vpos == field_halves - 1'b1);
        apply       = half_step && vpos_last && field && !vs_lock;
    end

    // Advance position, half-line, field and the field-start pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hpos <= '0; vpos <= '0; field <= 1'b0; irq <= 1'b0;
        end else begin
            hpos <= (hs_lock || at_line_end) ? '0 : hpos + 1'b1;
            irq  <= half_step && vpos_last && !vs_lock;
            if (vs_lock) begin
                vpos  <= eq_count;
                field <= mid_line;
            end else if (half_step) begin
                if (vpos_last) begin
                    vpos  <= '0;
                    field <= !field;
                end else begin
                    vpos <= vpos + 1'b1;
                end
            end
        end
    end

    p_hpos_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (master && !at_line_end) |=> (hpos == $past(hpos) + 1'b1));
    p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    p_slave_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hs_lock) |-> (hpos == '0));
endmodule

// File: rtl/raster_shaper.sv
// Sync pulse shaping (equalization, serration, hsync), active enable
// and the bottom-field flag, all derived from the counter state.
// Assumes serr_width <= half_len and eq_width <= half_len.
module raster_shaper #(
    parameter int CW = raster_pkg::RASTER_CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] half_len,
    input  logic [CW-1:0] hs_width,
    input  logic [CW-1:0] eq_width,
    input  logic [CW-1:0] serr_width,
    input  logic [CW-1:0] act_start,
    input  logic [CW-1:0] act_width,
    input  logic [CW-1:0] eq_count,
    input  logic [CW-1:0] vact_start,
    input  logic [CW-1:0] vact_count,
    input  logic [CW:0]   hpos,
    input  logic [CW-1:0] vpos,
    input  logic          field,
    output logic          hs_out,
    output logic          vs_out,
    output logic          de,
    output logic          btf
);
    logic [CW:0]   hh_w, act_end, vact_end;
    logic [CW+1:0] eq2, eq3, vpos_x;
    logic [CW-1:0] hh;
    logic          in_pre, in_serr, in_post, vs_prev, pending;

    // Region decode and pulse shaping
    always_comb begin
        hh_w     = (hpos < {1'b0, half_len}) ? hpos : hpos - {1'b0, half_len};
        hh       = hh_w[CW-1:0];
        vpos_x   = {2'b00, vpos};
        eq2      = {1'b0, eq_count, 1'b0};
        eq3      = eq2 + {2'b00, eq_count};
        in_pre   = vpos < eq_count;
        in_serr  = !in_pre && (vpos_x < eq2);
        in_post  = (vpos_x >= eq2) && (vpos_x < eq3);
        act_end  = {1'b0, act_start} + {1'b0, act_width};
        vact_end = {1'b0, vact_start} + {1'b0, vact_count};
        if (in_pre || in_post) hs_out = hh < eq_width;
        else if (in_serr)      hs_out = hh < (half_len - serr_width);
        else                   hs_out = hpos < {1'b0, hs_width};
        vs_out   = in_serr;
        de       = (hpos >= {1'b0, act_start}) && (hpos < act_end) &&
                   (vpos >= vact_start) && ({1'b0, vpos} < vact_end);
    end

    // Bottom flag follows the field at the first line start after vsync rises
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_prev <= 1'b0; pending <= 1'b0; btf <= 1'b0;
        end else begin
            vs_prev <= vs_out;
            if (pending && hpos == '0) begin
                btf     <= field;
                pending <= 1'b0;
            end
            if (vs_out && !vs_prev) pending <= 1'b1;
        end
    end

    p_btf_linestart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (btf != $past(btf)) |-> ($past(hpos) == '0));
endmodule

// File: rtl/raster_sync_gen.sv
// Top of the interlaced raster timing generator: parameter store,
// counters and pulse shaper. Reset values come from the DEF_* parameters.
// Assumes the sync pins are split into in/out/enable at the pad ring.
module raster_sync_gen
    import raster_pkg::*;
#(
    parameter int AW          = 4,
    parameter int DEF_HALF    = 858,
    parameter int DEF_HSW     = 126,
    parameter int DEF_EQW     = 63,
    parameter int DEF_SERW    = 126,
    parameter int DEF_ASTART  = 244,
    parameter int DEF_AWIDTH  = 1440,
    parameter int DEF_EQN     = 6,
    parameter int DEF_FLD     = 525,
    parameter int DEF_VSTART  = 40,
    parameter int DEF_VCOUNT  = 480,
    parameter int DEF_MASTER  = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [RASTER_CW-1:0] wr_data,
    input  logic                 hs_in,
    input  logic                 vs_in,
    output logic                 hs_out,
    output logic                 vs_out,
    output logic                 sync_oe,
    output logic                 active_de,
    output logic                 field_id,
    output logic                 bottom_flag,
    output logic [RASTER_CW:0]   hcount,
    output logic [RASTER_CW-1:0] vcount,
    output logic                 vsync_irq
);
    localparam int CW = RASTER_CW;
    localparam raster_cfg_t DEF_CFG = '{
        half_len:     CW'(DEF_HALF),   hs_width:   CW'(DEF_HSW),
        eq_width:     CW'(DEF_EQW),    serr_width: CW'(DEF_SERW),
        act_start:    CW'(DEF_ASTART), act_width:  CW'(DEF_AWIDTH),
        eq_count:     CW'(DEF_EQN),    field_halves: CW'(DEF_FLD),
        vact_start:   CW'(DEF_VSTART), vact_count: CW'(DEF_VCOUNT),
        master:       DEF_MASTER[0]
    };

    raster_cfg_t cfg;
    logic        apply;

    raster_cfg_regs #(.AW(AW), .RESET_CFG(DEF_CFG)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .apply(apply), .live(cfg)
    );

    raster_counters #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .half_len(cfg.half_len),
        .eq_count(cfg.eq_count), .field_halves(cfg.field_halves),
        .master(cfg.master), .hs_in(hs_in), .vs_in(vs_in),
        .hpos(hcount), .vpos(vcount), .field(field_id),
        .apply(apply), .irq(vsync_irq)
    );

    raster_shaper #(.CW(CW)) u_shp (
        .clk(clk), .rst_n(rst_n), .half_len(cfg.half_len),
        .hs_width(cfg.hs_width), .eq_width(cfg.eq_width),
        .serr_width(cfg.serr_width), .act_start(cfg.act_start),
        .act_width(cfg.act_width), .eq_count(cfg.eq_count),
        .vact_start(cfg.vact_start), .vact_count(cfg.vact_count),
        .hpos(hcount), .vpos(vcount), .field(field_id),
        .hs_out(hs_out), .vs_out(vs_out), .de(active_de), .btf(bottom_flag)
    );

    assign sync_oe = cfg.master;
endmodule

// File: tb/tb_raster_sync_gen.sv
// Clock-by-clock comparison against an arithmetic raster model,
// followed by directed slave-mode lock cases.
module tb_raster_sync_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic        hs_in = 1'b0, vs_in = 1'b0;
    logic        hs_out, vs_out, sync_oe, active_de, field_id, bottom_flag, vsync_irq;
    logic [12:0] hcount;
    logic [11:0] vcount;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit done = 0;
    int c[11];      // expected live configuration
    int nc[11];     // configuration to be written
    int prev_btf = 0;

    always #10 clk = ~clk;

    raster_sync_gen #(
        .DEF_HALF(20), .DEF_HSW(3), .DEF_EQW(2), .DEF_SERW(3),
        .DEF_ASTART(6), .DEF_AWIDTH(24), .DEF_EQN(3), .DEF_FLD(25),
        .DEF_VSTART(10), .DEF_VCOUNT(12), .DEF_MASTER(1)
    ) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hs_in(hs_in), .vs_in(vs_in), .hs_out(hs_out),
        .vs_out(vs_out), .sync_oe(sync_oe), .active_de(active_de),
        .field_id(field_id), .bottom_flag(bottom_flag), .hcount(hcount),
        .vcount(vcount), .vsync_irq(vsync_irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Expected outputs at cycle t of a frame, from the requirement formulas
    task automatic model_check(input int t, input bit first, input string ph);
        int H = c[0], L = 2 * c[0], E = c[6], F = c[7];
        int hp = t % L, half = t / H, vh = half % F, fld = (half / F) % 2, hh = t % H;
        int ehs, evs, ede, eirq, ebtf, tl0, tl1;
        string hst;
        if (vh < E || (vh >= 2 * E && vh < 3 * E)) begin ehs = int'(hh < c[2]); hst = "R4 hs_out "; end
        else if (vh < 2 * E) begin ehs = int'(hh < H - c[3]); hst = "R5 hs_out "; end
        else begin ehs = int'(hp < c[1]); hst = "R3 hs_out "; end
        evs  = int'(vh >= E && vh < 2 * E);
        ede  = int'(hp >= c[4] && hp < c[4] + c[5] && vh >= c[8] && vh < c[8] + c[9]);
        eirq = int'(hh == 0 && vh == 0 && !(t == 0 && first));
        tl0  = ((E * H) / L + 1) * L;
        tl1  = (((F + E) * H) / L + 1) * L;
        ebtf = (t > tl1) ? 1 : (t > tl0) ? 0 : prev_btf;
        chk({"R1 hcount ", ph}, int'(hcount), hp);
        chk({"R2 vcount ", ph}, int'(vcount), vh);
        chk({"R2 field_id ", ph}, int'(field_id), fld);
        chk({hst, ph}, int'(hs_out), ehs);
        chk({"R5 vs_out ", ph}, int'(vs_out), evs);
        chk({"R6 active_de ", ph}, int'(active_de), ede);
        chk({"R7 bottom_flag ", ph}, int'(bottom_flag), ebtf);
        chk({"R9 vsync_irq ", ph}, int'(vsync_irq), eirq);
        chk({"R10 sync_oe ", ph}, int'(sync_oe), c[10]);
    endtask

    // One whole frame; optional writes of nc[wlo..whi] starting at cycle wt
    task automatic run_frame(input bit first, input string ph,
                             input int wt, input int wlo, input int whi);
        int len = 2 * c[7] * c[0];
        for (int t = 0; t < len; t++) begin
            #1 model_check(t, first, ph);
            if (wt >= 0 && t >= wt && t - wt <= whi - wlo) begin
                wr_en = 1'b1; wr_addr = 4'(wlo + t - wt); wr_data = 12'(nc[wlo + t - wt]);
            end else begin
                wr_en = 1'b0;
            end
            @(posedge clk); @(negedge clk);
        end
        prev_btf = 1;
    endtask

    task automatic wait_for(input int h, input int vmin, input int vmax, output bit ok);
        ok = 0;
        for (int i = 0; i < 3000; i++) begin
            if (int'(hcount) == h && int'(vcount) >= vmin && int'(vcount) <= vmax) begin
                ok = 1; return;
            end
            @(posedge clk); @(negedge clk); #1;
        end
        chk("R10 wait for slave position", 0, 1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000 && !done) begin
            n_cmp++; n_bad++;
            $display("FAIL R1 watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        bit ok;
        int v;
        c = '{20, 3, 2, 3, 6, 24, 3, 25, 10, 12, 1};
        nc = '{16, 2, 1, 4, 4, 20, 2, 21, 6, 14, 1};
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        // Reset state (R1, R2, R7, R9, R10)
        chk("R1 reset hcount", int'(hcount), 0);
        chk("R2 reset vcount", int'(vcount), 0);
        chk("R2 reset field_id", int'(field_id), 0);
        chk("R7 reset bottom_flag", int'(bottom_flag), 0);
        chk("R9 reset vsync_irq", int'(vsync_irq), 0);
        chk("R10 reset sync_oe", int'(sync_oe), 1);
        rst_n = 1'b1;
        run_frame(1'b1, "defaults", -1, 0, 0);
        // R8: writes mid-frame must not disturb the running frame
        run_frame(1'b0, "R8 held", 100, 0, 10);
        c = nc;
        run_frame(1'b0, "R8 applied", -1, 0, 0);
        nc[10] = 0;
        run_frame(1'b0, "R8 mode staged", 50, 10, 10);
        c[10] = 0;
        run_frame(1'b0, "R10 slave free-run", -1, 0, 0);

        // R10: edge near line end locks and adds one half-line
        #1 wait_for(28, 1, 18, ok);
        v = int'(vcount);
        hs_in = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk); #1;
        chk("R10 lock hcount", int'(hcount), 0);
        chk("R10 lock vcount", int'(vcount), v + 1);
        hs_in = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk); #1;
        chk("R10 count after lock", int'(hcount), 5);
        // R10: edge at mid-line is ignored
        wait_for(15, 1, 18, ok);
        v = int'(vcount);
        hs_in = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk); #1;
        chk("R10 midline ignored hcount", int'(hcount), 17);
        chk("R10 midline ignored vcount", int'(vcount), v + 1);
        hs_in = 1'b0;
        chk("R10 slave sync_oe", int'(sync_oe), 0);
        // R11: vsync at line start -> top field
        wait_for(0, 0, 20, ok);
        vs_in = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk); #1;
        chk("R11 vs lock vcount", int'(vcount), 2);
        chk("R11 vs lock field top", int'(field_id), 0);
        chk("R11 vs lock vs_out", int'(vs_out), 1);
        vs_in = 1'b0;
        // R11: vsync at mid-line -> bottom field
        wait_for(15, 0, 20, ok);
        vs_in = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk); #1;
        chk("R11 vs lock vcount mid", int'(vcount), 2);
        chk("R11 vs lock field bottom", int'(field_id), 1);
        vs_in = 1'b0;

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule